// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Input Interface

This block is the digital front end of a 12-bit converter. It runs on a single fast clock at the converter update rate, which is twice the word rate of each input port. A divide-by-two phase is derived inside the block and driven out on a pin. Upstream logic uses that pin to time its data changes. A synchronous reset puts the phase at a known fast-clock edge. Both input ports load only on the fast-clock edges where this phase rises.

The operating mode is taken from a mode input while reset is held. In interleaved mode, both ports are captured together on every rising-phase edge. The output register then shows the first port's word for one fast cycle and the second port's word for the next, so the output runs at the full fast rate. In non-interleaved mode, a two-bit select chooses which port latch loads on a rising-phase edge. That word moves to the output register on the following rising-phase edge, which gives two stages of buffering. A complementary code, equal to full scale minus the output code, comes out alongside the output.

Top module: `ilvfe_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block sets `phaseOut` to 1, `codeOut` to 0 and `codeCompOut` to 4095. `rst` is synchronous.
- R2: After `rst` is released, `phaseOut` goes to 0 on the first rising edge and back to 1 on the second. From then on it toggles on every rising edge. A capture edge is an edge on which `phaseOut` goes from 0 to 1.
- R3: In interleaved mode, `portA` and `portB` are both captured on every capture edge, and only on capture edges.
- R4: In interleaved mode, the word captured from `portA` appears on `codeOut` after the edge that follows a capture edge. The word from `portB` appears after the next edge, which is the next capture edge. `codeOut` stays 0 until the edge after the first capture edge.
- R5: A change on `portA` or `portB` that does not span a capture edge has no effect on `codeOut`.
- R6: In non-interleaved mode (`modeIlv` = 0 during reset), `selPort` = 2'b01 loads `portA` on a capture edge and `selPort` = 2'b10 loads `portB`. The loaded word appears on `codeOut` after the next capture edge. `codeOut` changes only on capture edges.
- R7: In non-interleaved mode, `selPort` = 2'b00 or 2'b11 loads nothing. Each later capture edge presents the most recently loaded word again.
- R8: `codeCompOut` always equals 4095 minus `codeOut`.
- R9: `modeIlv` is sampled only while `rst` is high (1 = interleaved). Changes to it while `rst` is low have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at the output update rate |
| rst | input | 1 | Synchronous reset and phase alignment, active high |
| modeIlv | input | 1 | Mode select, sampled during reset: 1 interleaved, 0 single port |
| selPort | input | 2 | Port select in non-interleaved mode: 01 port A, 10 port B, others none |
| portA | input | 12 | First input word port |
| portB | input | 12 | Second input word port |
| phaseOut | output | 1 | Half-rate phase; rises on capture edges |
| codeOut | output | 12 | Converter code |
| codeCompOut | output | 12 | Complementary code, 4095 minus codeOut |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `modeIlv` may change freely while `rst` is low, and that the frozen mode register alone decides the behaviour. The bench holds reset high from time zero. It changes every input only on falling clock edges. It moves the port words away from their captured values between capture edges, and it flips `modeIlv` after reset is released. This way the ignore rules are covered by what is observed at the ports.

// File: rtl/ilvfe_pkg.sv
package ilvfe_pkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic pickA;
    logic pickB;
  } ctrlStrobes_t;
endpackage

// File: rtl/ilvfe_ctrl.sv
module ilvfe_ctrl
  import ilvfe_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeIlv,
  input  logic [SEL_W-1:0] selPort,
  output logic             phaseOut,
  output ctrlStrobes_t     str
);
  localparam logic [SEL_W-1:0] SEL_A = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_B = SEL_W'(2);

  logic phaseQ;
  logic ilvQ;
  logic srcIsB;
  logic capEdge;
  logic wantA;
  logic wantB;

  always_comb begin
    capEdge = ~phaseQ;
    wantA   = (selPort == SEL_A);
    wantB   = (selPort == SEL_B);
    str.loadA = capEdge & (ilvQ | wantA);
    str.loadB = capEdge & (ilvQ | wantB);
    if (ilvQ) begin
      str.pickA = phaseQ;
      str.pickB = capEdge;
    end else begin
      str.pickA = capEdge & ~srcIsB;
      str.pickB = capEdge & srcIsB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= 1'b1;
      ilvQ   <= modeIlv;
      srcIsB <= 1'b0;
    end else begin
      phaseQ <= ~phaseQ;
      if (capEdge && !ilvQ) begin
        if (wantA) srcIsB <= 1'b0;
        else if (wantB) srcIsB <= 1'b1;
      end
    end
  end

  assign phaseOut = phaseQ;

  p_reset_phase_r1: assert property (@(posedge clk) rst |=> phaseQ);
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phaseQ != $past(phaseQ)));
  p_no_load_off_edge_r3: assert property (@(posedge clk) disable iff (rst)
    phaseQ |-> !(str.loadA || str.loadB));
  p_pair_load_r3: assert property (@(posedge clk) disable iff (rst)
    (ilvQ && !phaseQ) |-> (str.loadA && str.loadB));
  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ilvQ));
endmodule

// File: rtl/ilvfe_datapath.sv
module ilvfe_datapath
  import ilvfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      str,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  output logic [DATA_W-1:0] codeOut,
  output logic [DATA_W-1:0] compOut
);
  localparam logic [DATA_W-1:0] CODE_MAX = '1;

  logic [DATA_W-1:0] latchA;
  logic [DATA_W-1:0] latchB;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchA <= '0;
      latchB <= '0;
      outReg <= '0;
    end else begin
      if (str.loadA) latchA <= portA;
      if (str.loadB) latchB <= portB;
      if (str.pickA) outReg <= latchA;
      else if (str.pickB) outReg <= latchB;
    end
  end

  assign codeOut = outReg;
  assign compOut = CODE_MAX - outReg;

  p_one_pick_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.pickA, str.pickB}));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!str.pickA && !str.pickB) |=> $stable(outReg));
  p_comp_r8: assert property (@(posedge clk) disable iff (rst)
    (codeOut ^ compOut) == CODE_MAX);
endmodule

// File: rtl/ilvfe_top.sv
module ilvfe_top
  import ilvfe_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeIlv,
  input  logic [SEL_W-1:0]  selPort,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  output logic              phaseOut,
  output logic [DATA_W-1:0] codeOut,
  output logic [DATA_W-1:0] codeCompOut
);
  ctrlStrobes_t str;

  ilvfe_ctrl #(.SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rst(rst), .modeIlv(modeIlv), .selPort(selPort),
    .phaseOut(phaseOut), .str(str)
  );

  ilvfe_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .str(str), .portA(portA), .portB(portB),
    .codeOut(codeOut), .compOut(codeCompOut)
  );
endmodule

// File: tb/ilvfe_top_tb.sv
module ilvfe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        modeIlv = 1'b1;
  logic [1:0]  selPort = 2'b00;
  logic [11:0] portA = '0;
  logic [11:0] portB = '0;
  logic        phaseOut;
  logic [11:0] codeOut;
  logic [11:0] codeCompOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam int NV = 8;
  localparam logic [11:0] VA [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                      12'h123, 12'h001, 12'hABC, 12'h3C3};
  localparam logic [11:0] VB [NV] = '{12'hFFF, 12'h000, 12'h7FF, 12'h800,
                                      12'h456, 12'hFFE, 12'h0F0, 12'hC3C};

  always #5 clk = ~clk;

  ilvfe_top dut_i (
    .clk(clk), .rst(rst), .modeIlv(modeIlv), .selPort(selPort),
    .portA(portA), .portB(portB), .phaseOut(phaseOut),
    .codeOut(codeOut), .codeCompOut(codeCompOut)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkCode(input string req, input logic [11:0] exp);
    check(req, codeOut, exp);
    check({req, " R8 complement"}, codeCompOut, 12'hFFF - exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check("R1 phase in reset", {11'b0, phaseOut}, 12'd1);
    checkCode("R1 code in reset", 12'h000);

    // Interleaved run; R9: mode flips low after release and must be ignored
    rst = 1'b0;
    tick();                                   // edge 1
    modeIlv = 1'b0;
    check("R2 phase low after edge 1", {11'b0, phaseOut}, 12'd0);
    checkCode("R4 code zero before capture", 12'h000);
    for (int i = 0; i < NV; i++) begin
      portA = VA[i];
      portB = VB[i];
      tick();                                 // capture edge
      check("R2 phase high on capture edge", {11'b0, phaseOut}, 12'd1);
      checkCode("R4 port B word on capture edge", (i == 0) ? 12'h000 : VB[i-1]);
      portA = 12'h5A5;                        // R5: off-edge changes ignored
      portB = 12'hA5A;
      tick();
      check("R2 phase low between captures", {11'b0, phaseOut}, 12'd0);
      checkCode("R4 R9 R5 port A word after capture", VA[i]);
    end
    portA = 12'h0DD;
    portB = 12'h0EE;
    tick();
    checkCode("R4 last port B word", VB[NV-1]);

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    modeIlv = 1'b0;
    tick();
    check("R1 phase after mid-run reset", {11'b0, phaseOut}, 12'd1);
    checkCode("R1 code after mid-run reset", 12'h000);
    tick();
    rst = 1'b0;
    tick();                                   // edge 1, non-interleaved
    modeIlv = 1'b1;                           // R9: ignored
    check("R2 phase low after release", {11'b0, phaseOut}, 12'd0);

    // R6 / R7 non-interleaved
    selPort = 2'b01; portA = 12'h123; portB = 12'h456;
    tick();
    checkCode("R6 nothing before second capture", 12'h000);
    portA = 12'h999;
    tick();
    checkCode("R6 R5 code stable off edge", 12'h000);
    selPort = 2'b10; portA = 12'h777; portB = 12'hABC;
    tick();
    checkCode("R6 R9 port A word one capture later", 12'h123);
    tick();
    checkCode("R6 hold off edge", 12'h123);
    selPort = 2'b00; portA = 12'h001; portB = 12'h002;
    tick();
    checkCode("R6 port B word one capture later", 12'hABC);
    tick();
    selPort = 2'b11; portA = 12'h003; portB = 12'h004;
    tick();
    checkCode("R7 select 11 repeats last word", 12'hABC);
    tick();
    selPort = 2'b01; portA = 12'hFFF;
    tick();
    checkCode("R7 select 00 loaded nothing", 12'hABC);
    tick();
    selPort = 2'b00; portA = 12'h000;
    tick();
    checkCode("R6 R8 full-scale word", 12'hFFF);
    tick();
    tick();
    checkCode("R7 repeat after select 00", 12'hFFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule